// File: doc/BRIEF.md
# Protection-Aware Programming Checksum Engine

This engine produces the 16-bit checksum a programmer reports for a flash image. It does not hold memory itself. It fetches words through a read port made of a request, an address and a valid strobe. After a start pulse it first fetches the 14-bit configuration word. The code-protect bit in that word then decides which of two summing algorithms runs.

When protection is off, the engine adds every user program word in ascending address order. When protection is on, the program array is not read. Instead, the low nibble of each of the four user ID words is packed into one 16-bit value. In both modes the configuration word, ANDed with a mask of its implemented bits, is added to the result. Every addition wraps at 16 bits. The result appears together with a one-cycle done pulse, and busy covers the whole fetch phase.

Top module: `cksum_engine`

## Requirements
- R1: After reset, busy_o, done_o and rd_req_o are 0 and result_o is 0x0000.
- R2: The first word requested after an accepted start is the configuration word at address 0x2007.
- R3: When bit 6 of the configuration word is 1 (protection off), the engine requests addresses 0x000 to 0xFFF in ascending order and adds each word. A blank image (all words 0x3FFF, configuration 0x3FFF) gives 0x1D78.
- R4: When bit 6 of the configuration word is 0 (protection on), the engine requests only addresses 0x2000 to 0x2003. Their low nibbles are placed at bits 15:12, 11:8, 7:4 and 3:0 respectively. For example, IDs 6, 7, 1, 2 with configuration 0x3FBF give 0x944A.
- R5: The configuration word is ANDed with the mask 0x2D78 before it is added, so bits outside the mask have no effect on the result.
- R6: All sums are taken modulo 2^16, and any carry out of bit 15 is dropped.
- R7: User ID bits above bit 3 have no effect on the result.
- R8: A word is consumed only in a cycle where rd_req_o and rd_vld_i are both high. While a request waits, its address holds steady. The result does not depend on read latency.
- R9: busy_o is high from the cycle after an accepted start until done_o rises. done_o is a one-cycle pulse with busy_o low. result_o is valid at done_o and holds until the next accepted start.
- R10: A start pulse while busy_o is high is ignored, and the running computation finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a checksum; accepted only when idle |
| busy_o | output | 1 | Fetch and accumulate in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 16 | Checksum |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 14 | Word address of the request |
| rd_vld_i | input | 1 | Read data valid; completes the request |
| rd_data_i | input | 14 | Read data word |

## Verification
Several properties are checked on every cycle by assertions. A waiting request holds its address. The configuration address is the first address after busy rises. The done pulse lasts one cycle and follows busy. The result holds after done. The last address fetched matches the mode that was chosen. The bench scenarios are the only way to show the arithmetic itself: the address order across both modes, nibble packing, masking, 16-bit wraparound, independence from read latency, and that a start pulse during a run is ignored.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG,
    ST_PROG,
    ST_UID,
    ST_DONE
  } phase_e;
endpackage

// File: rtl/cksum_seq.sv
module cksum_seq
  import cksum_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int PROG_WORDS = 4096,
  parameter int UID_WORDS  = 4,
  parameter int CFG_ADDR   = 'h2007,
  parameter int UID_BASE   = 'h2000,
  parameter int IDX_W      = $clog2(PROG_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_vld_i,
  input  logic              cp_bit_i,
  output phase_e            phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              take_o,
  output logic              clr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] PROG_LAST = IDX_W'(PROG_WORDS - 1);
  localparam logic [IDX_W-1:0] UID_LAST  = IDX_W'(UID_WORDS - 1);

  phase_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             prot_q, prot_d;

  assign busy_o   = (state_q == ST_CFG) || (state_q == ST_PROG) || (state_q == ST_UID);
  assign done_o   = (state_q == ST_DONE);
  assign rd_req_o = busy_o;
  assign take_o   = rd_req_o & rd_vld_i;
  assign clr_o    = (state_q == ST_IDLE) & start_i;
  assign phase_o  = state_q;
  assign idx_o    = idx_q;

  always_comb begin
    unique case (state_q)
      ST_CFG:  rd_addr_o = ADDR_W'(CFG_ADDR);
      ST_PROG: rd_addr_o = ADDR_W'(idx_q);
      ST_UID:  rd_addr_o = ADDR_W'(UID_BASE) + ADDR_W'(idx_q);
      default: rd_addr_o = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    prot_d  = prot_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CFG;
        idx_d   = '0;
      end
      ST_CFG: if (take_o) begin
        // protect bit low selects the ID packing path
        prot_d  = ~cp_bit_i;
        state_d = cp_bit_i ? ST_PROG : ST_UID;
        idx_d   = '0;
      end
      ST_PROG: if (take_o) begin
        if (idx_q == PROG_LAST) state_d = ST_DONE;
        else idx_d = idx_q + 1'b1;
      end
      ST_UID: if (take_o) begin
        if (idx_q == UID_LAST) state_d = ST_DONE;
        else idx_d = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      prot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      prot_q  <= prot_d;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_vld_i |=> rd_req_o && $stable(rd_addr_o));
  // R2
  cfg_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> rd_addr_o == ADDR_W'(CFG_ADDR));
  // R3
  prog_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !prot_q |-> $past(rd_addr_o) == ADDR_W'(PROG_WORDS - 1));
  // R4
  uid_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && prot_q |-> $past(rd_addr_o) == ADDR_W'(UID_BASE + UID_WORDS - 1));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: rtl/cksum_term.sv
module cksum_term
  import cksum_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int SUM_W     = 16,
  parameter int NIB_W     = 4,
  parameter int UID_WORDS = 4,
  parameter int CFG_MASK  = 'h2D78,
  parameter int SEL_W     = $clog2(UID_WORDS)
) (
  input  phase_e            phase_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  term_o
);
  logic [SUM_W-1:0] slot [UID_WORDS];

  // first ID lands in the top nibble, last in the bottom
  for (genvar g = 0; g < UID_WORDS; g++) begin : g_slot
    assign slot[g] = SUM_W'(data_i[NIB_W-1:0]) << (NIB_W * (UID_WORDS - 1 - g));
  end

  always_comb begin
    unique case (phase_i)
      ST_CFG:  term_o = SUM_W'(data_i) & SUM_W'(CFG_MASK);
      ST_PROG: term_o = SUM_W'(data_i);
      ST_UID:  term_o = slot[sel_i];
      default: term_o = '0;
    endcase
  end
endmodule

// File: rtl/cksum_acc.sv
module cksum_acc #(
  parameter int SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [SUM_W-1:0] term_i,
  output logic [SUM_W-1:0] acc_o
);
  // wraps modulo 2^SUM_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (add_i) acc_o <= acc_o + term_i;
  end
endmodule

// File: rtl/cksum_engine.sv
module cksum_engine
  import cksum_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int SUM_W      = 16,
  parameter int ADDR_W     = 14,
  parameter int PROG_WORDS = 4096,
  parameter int UID_WORDS  = 4,
  parameter int NIB_W      = 4,
  parameter int CFG_ADDR   = 'h2007,
  parameter int UID_BASE   = 'h2000,
  parameter int CFG_MASK   = 'h2D78,
  parameter int CP_BIT     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SUM_W-1:0]  result_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_vld_i,
  input  logic [DATA_W-1:0] rd_data_i
);
  localparam int IDX_W = $clog2(PROG_WORDS);
  localparam int SEL_W = $clog2(UID_WORDS);

  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic             take, clr;
  logic [SUM_W-1:0] term;

  cksum_seq #(
    .ADDR_W(ADDR_W), .PROG_WORDS(PROG_WORDS), .UID_WORDS(UID_WORDS),
    .CFG_ADDR(CFG_ADDR), .UID_BASE(UID_BASE), .IDX_W(IDX_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_vld_i(rd_vld_i),
    .cp_bit_i(rd_data_i[CP_BIT]), .phase_o(phase), .idx_o(idx),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .take_o(take), .clr_o(clr),
    .busy_o(busy_o), .done_o(done_o)
  );

  cksum_term #(
    .DATA_W(DATA_W), .SUM_W(SUM_W), .NIB_W(NIB_W), .UID_WORDS(UID_WORDS),
    .CFG_MASK(CFG_MASK), .SEL_W(SEL_W)
  ) u_term (
    .phase_i(phase), .sel_i(idx[SEL_W-1:0]), .data_i(rd_data_i), .term_o(term)
  );

  cksum_acc #(.SUM_W(SUM_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .add_i(take),
    .term_i(term), .acc_o(result_o)
  );

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(result_o));
endmodule

// File: tb/cksum_engine_bench.sv
`timescale 1ns/1ps
module cksum_engine_bench;
  typedef struct packed {
    logic [13:0] cfg;
    logic [13:0] u0, u1, u2, u3;
    logic [1:0]  kind;   // 0 blank, 1 zeros, 2 ramp
    logic [13:0] seed;
    logic [1:0]  lat;
    logic        has_lit;
    logic [15:0] lit;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{14'h3FFF, 14'h0,    14'h0,    14'h0, 14'h0,    2'd0, 14'h0,    2'd0, 1'b1, 16'h1D78}, // R3 R6 blank
    '{14'h3FBF, 14'h6,    14'h7,    14'h1, 14'h2,    2'd0, 14'h0,    2'd0, 1'b1, 16'h944A}, // R4
    '{14'h3FBF, 14'h3FF6, 14'h3F87, 14'h1, 14'h2002, 2'd2, 14'h0,    2'd1, 1'b1, 16'h944A}, // R7 R8
    '{14'h0040, 14'h5,    14'h5,    14'h5, 14'h5,    2'd2, 14'h1234, 2'd2, 1'b0, 16'h0},    // R3 R8 ramp
    '{14'h2D78, 14'h0,    14'h0,    14'h0, 14'h0,    2'd0, 14'h0,    2'd0, 1'b1, 16'h1D78}, // R5
    '{14'h12C5, 14'h0,    14'h0,    14'h0, 14'h0,    2'd1, 14'h0,    2'd1, 1'b1, 16'h0040}, // R5 zeros
    '{14'h0000, 14'hF,    14'hF,    14'hF, 14'hF,    2'd0, 14'h0,    2'd1, 1'b1, 16'hFFFF}, // R4
    '{14'h3FBF, 14'hF,    14'hF,    14'hF, 14'hF,    2'd0, 14'h0,    2'd2, 1'b1, 16'h2D37}  // R6 carry
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        busy_o, done_o, rd_req_o;
  logic [15:0] result_o;
  logic [13:0] rd_addr_o;
  logic        rd_vld_i = 1'b0;
  logic [13:0] rd_data_i = '0;

  always #4 clk_i = ~clk_i;

  cksum_engine u_cksum_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i)
  );

  int   errors = 0, checks = 0;
  vec_t cur;
  int   nread = 0, order_err = 0, cnt = 0;
  logic timed_out = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] word_at(input vec_t v, input int a);
    case (v.kind)
      2'd0:    return 14'h3FFF;
      2'd1:    return 14'h0;
      default: return 14'((a * 37) ^ int'(v.seed));
    endcase
  endfunction

  function automatic logic [13:0] mem_at(input vec_t v, input int a);
    if (a == 'h2007) return v.cfg;
    if (a == 'h2000) return v.u0;
    if (a == 'h2001) return v.u1;
    if (a == 'h2002) return v.u2;
    if (a == 'h2003) return v.u3;
    return word_at(v, a);
  endfunction

  function automatic int exp_addr(input vec_t v, input int n);
    if (n == 0) return 'h2007;
    return v.cfg[6] ? (n - 1) : ('h2000 + n - 1);
  endfunction

  function automatic logic [15:0] model(input vec_t v);
    logic [15:0] s;
    s = 16'h0;
    if (v.cfg[6]) begin
      for (int a = 0; a < 4096; a++) s = s + 16'(word_at(v, a));
    end else begin
      s = {v.u0[3:0], v.u1[3:0], v.u2[3:0], v.u3[3:0]};
    end
    return s + ({2'b00, v.cfg} & 16'h2D78);
  endfunction

  // memory responder with per-vector latency
  initial begin
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        rd_vld_i = 1'b0;
        cnt = 0;
      end else begin
        if (rd_vld_i) cnt = 0;
        if (rd_req_o && cnt >= int'(cur.lat)) begin
          rd_vld_i  = 1'b1;
          rd_data_i = mem_at(cur, int'(rd_addr_o));
          if (int'(rd_addr_o) != exp_addr(cur, nread)) order_err++;
          nread++;
        end else begin
          rd_vld_i = 1'b0;
          if (rd_req_o) cnt++;
        end
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk_i);
      n++;
    end
    if (!done_o) begin
      errors++;
      checks++;
      timed_out = 1'b1;
      $display("FAIL watchdog act=0x0 exp=0x1");
    end
  endtask

  task automatic kick();
    nread = 0;
    order_err = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  initial begin
    logic [15:0] res, exp;
    cur = VECS[0];
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !done_o && !rd_req_o, "R1 idle outputs", {busy_o, done_o, rd_req_o}, 0);
    chk(result_o == 16'h0, "R1 result", result_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!rd_req_o, "R8 no request while idle", rd_req_o, 0);

    for (int i = 0; i < NV && !timed_out; i++) begin
      cur = VECS[i];
      kick();
      wait_done();
      if (timed_out) break;
      res = result_o;
      exp = model(cur);
      chk(res == exp, cur.cfg[6] ? "R3/R5/R6 unprotected sum" : "R4/R7 protected sum", res, exp);
      if (cur.has_lit) chk(res == cur.lit, "R5/R6 known value", res, cur.lit);
      chk(nread == (cur.cfg[6] ? 4097 : 5), "R2/R3/R4 read count", nread, cur.cfg[6] ? 4097 : 5);
      chk(order_err == 0, "R2/R3/R4 address order", order_err, 0);
      repeat (2) @(negedge clk_i);
    end

    if (!timed_out) begin
      // R9 handshake timing, R10 start ignored while busy
      cur = VECS[1];
      kick();
      chk(busy_o && !done_o, "R9 busy after start", {busy_o, done_o}, 2);
      @(negedge clk_i) start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      wait_done();
      if (!timed_out) begin
        res = result_o;
        chk(!busy_o, "R9 busy low at done", busy_o, 0);
        chk(res == 16'h944A, "R10 result after ignored start", res, 16'h944A);
        chk(nread == 5 && order_err == 0, "R10 reads unchanged", nread, 5);
        @(negedge clk_i);
        chk(!done_o, "R9 done one cycle", done_o, 0);
        repeat (3) @(negedge clk_i);
        chk(result_o == res && !busy_o, "R9 result held", result_o, res);
        // R8 latency independence: lat 0 vs lat 2 on same image
        cur = VECS[3];
        cur.lat = 2'd0;
        kick();
        wait_done();
        if (!timed_out) chk(result_o == model(VECS[3]), "R8 latency independent", result_o, model(VECS[3]));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule